// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Centre Strobe

This block takes a five-digit decimal result, held as BCD, together with an out-of-range flag, and time-shares the digits onto one 4-bit BCD bus. While a digit's value sits on the bus, a matching active-high digit-enable line is raised, so a display or an external latch can tell which position the bus is carrying. The most significant position is shown first and its slot is one clock longer than the others. The scan then repeats without stopping.

Each accepted result rearms a strobe: during the first pass after the result, an active-low pulse lasting half a clock marks the middle of every digit slot. Later passes carry no strobe. If the result was out of range, the bus carries zeros. The digit enables drop after the fifth strobe and stay low until the next result arrives, so a display blinks. A new result always wins: it is taken in the cycle it is offered and restarts the scan at the most significant digit. The result input has a valid line and no ready line. The block never applies back-pressure, and a `res_valid` high on any clock edge replaces the held result.

Top module: `digit_scanner`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted result, all digit enables are 0, `bcd_out` is 0 and `strobe_n` is 1.
- R2: At most one digit enable is high at any time. Enables run from bit 4 (most significant) down to bit 0, and the pass then wraps back to bit 4 and continues with no gap.
- R3: The slot for bit 4 lasts 201 clocks and each other slot lasts 200 clocks. A full pass is 1001 clocks.
- R4: `bcd_out` carries the held digit of the enabled position and changes in the same cycle as the enable. Digit k sits at `res_digits[4k+3:4k]`, k=4 is the most significant digit, and `bcd_out[3]` has weight 8. `bcd_out` is 0 when no enable is high.
- R5: In the first pass after a result, `strobe_n` goes low once per slot, five times in total. The pulse falls in the 101st clock of the bit-4 slot and in the 100th clock of each other slot.
- R6: A strobe pulse covers only the low half of its clock cycle. `strobe_n` stays high while `clk` is high.
- R7: Passes after the first carry no strobe pulse.
- R8: A result accepted in the middle of a pass restarts the scan at bit 4 in the next cycle, with the new digits, and rearms the five strobes.
- R9: When the held result is flagged out of range, `bcd_out` is 0 throughout, and the five strobes of the first pass still occur.
- R10: When the held result is out of range, all digit enables go low in the cycle after the fifth strobe and stay low until the next result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobe pulses use its low phase |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | New result present; always accepted |
| res_digits | input | 20 | Five BCD digits, digit 4 most significant |
| res_ovr | input | 1 | Out-of-range flag for the offered result |
| digit_en | output | 5 | One-hot digit enables, bit 4 = most significant |
| bcd_out | output | 4 | BCD value of the enabled digit |
| strobe_n | output | 1 | Active-low half-clock strobe at slot centres |

## Verification
The hardest case to reach is a restart that lands in the middle of a slot while strobes are still armed. The restart must cancel the remaining strobes of the old pass and rearm five strobes for the new one, with no stray pulse at the switch. The bench offers a first result, lets 351 cycles pass so that the scan is partway through the second slot, and then offers a different result. It then follows the new pass clock by clock and counts its strobes. A second hard case is the blank period after an out-of-range result, which can only end with a new result. The bench holds the blank for 1500 cycles and then offers a normal result to show that scanning resumes.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int N_DIG    = 5,
  parameter int SLOT_LEN = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ovr,
  output logic [N_DIG-1:0] digit_en,
  output logic             stb_req
);
  localparam int CNT_W = $clog2(SLOT_LEN + 1);
  localparam int IDX_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;
  localparam int HALF  = SLOT_LEN / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             running_q;
  logic             armed_q;

  logic             is_msd, is_lsd, at_end, at_mid;

  assign is_msd = (idx_q == '0);
  assign is_lsd = (idx_q == IDX_W'(N_DIG - 1));
  assign at_end = is_msd ? (cnt_q == CNT_W'(SLOT_LEN)) : (cnt_q == CNT_W'(SLOT_LEN - 1));
  assign at_mid = is_msd ? (cnt_q == CNT_W'(HALF))     : (cnt_q == CNT_W'(HALF - 1));

  assign stb_req = running_q && armed_q && at_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      idx_q     <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (start) begin
      cnt_q     <= '0;
      idx_q     <= '0;
      running_q <= 1'b1;
      armed_q   <= 1'b1;
    end else if (running_q) begin
      if (stb_req && is_lsd && ovr) begin
        running_q <= 1'b0;
        armed_q   <= 1'b0;
      end else if (at_end) begin
        cnt_q <= '0;
        if (is_lsd) begin
          idx_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_DIG; g++) begin : g_en
    assign digit_en[g] = running_q && (idx_q == IDX_W'(N_DIG - 1 - g));
  end
endmodule

// File: rtl/bcd_mux.sv
module bcd_mux
  import scan_pkg::*;
#(
  parameter int N_DIG = 5
) (
  input  logic [N_DIG*BCD_W-1:0] digits,
  input  logic [N_DIG-1:0]       digit_en,
  input  logic                   blank,
  output bcd_t                   bcd
);
  always_comb begin
    bcd = '0;
    for (int k = 0; k < N_DIG; k++) begin
      if (digit_en[k]) bcd = bcd | digits[k*BCD_W +: BCD_W];
    end
    if (blank) bcd = '0;
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen (
  input  logic clk,
  input  logic stb_req,
  output logic strobe_n
);
  assign strobe_n = ~(stb_req & ~clk);
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
  import scan_pkg::*;
#(
  parameter int N_DIG    = 5,
  parameter int SLOT_LEN = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   res_valid,
  input  logic [N_DIG*BCD_W-1:0] res_digits,
  input  logic                   res_ovr,
  output logic [N_DIG-1:0]       digit_en,
  output logic [BCD_W-1:0]       bcd_out,
  output logic                   strobe_n
);
  logic [N_DIG*BCD_W-1:0] digits_q;
  logic                   ovr_q;
  logic                   stb_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digits_q <= '0;
      ovr_q    <= 1'b0;
    end else if (res_valid) begin
      digits_q <= res_digits;
      ovr_q    <= res_ovr;
    end
  end

  scan_seq #(.N_DIG(N_DIG), .SLOT_LEN(SLOT_LEN)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (res_valid),
    .ovr      (ovr_q),
    .digit_en (digit_en),
    .stb_req  (stb_req)
  );

  bcd_mux #(.N_DIG(N_DIG)) mux_i (
    .digits   (digits_q),
    .digit_en (digit_en),
    .blank    (ovr_q),
    .bcd      (bcd_out)
  );

  strobe_gen stb_i (
    .clk      (clk),
    .stb_req  (stb_req),
    .strobe_n (strobe_n)
  );
endmodule

// File: rtl/digit_scanner_chk.sv
module digit_scanner_chk #(
  parameter int N_DIG = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [N_DIG-1:0] digit_en,
  input logic [3:0]       bcd_out,
  input logic             stb_req,
  input logic             ovr_q
);
  localparam logic [N_DIG-1:0] MSD_BIT = {1'b1, {(N_DIG-1){1'b0}}};

  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_en)); // R2

  AST_DRIVE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en != '0 && !res_valid) |=>
      (digit_en == '0 || digit_en == $past(digit_en) ||
       digit_en == (($past(digit_en) >> 1) | ($past(digit_en[0]) ? MSD_BIT : '0)))); // R2

  AST_RESTART_MSD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (digit_en == MSD_BIT)); // R8

  AST_IDLE_BCD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en == '0) |-> (bcd_out == 4'd0)); // R4

  AST_STB_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    stb_req |-> (digit_en != '0)); // R5

  AST_OVR_BCD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (bcd_out == 4'd0)); // R9
endmodule

bind digit_scanner digit_scanner_chk #(.N_DIG(N_DIG)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .digit_en  (digit_en),
  .bcd_out   (bcd_out),
  .stb_req   (stb_req),
  .ovr_q     (ovr_q)
);

// File: tb/digit_scanner_tb_top.sv
module digit_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 5;
  localparam int SLOT = 200;
  localparam int PASS_LEN = NDIG * SLOT + 1;
  localparam int LAST_STB_T = (SLOT + 1) + (NDIG - 2) * SLOT + (SLOT / 2 - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [19:0] res_digits = '0;
  logic        res_ovr = 1'b0;
  logic [4:0]  digit_en;
  logic [3:0]  bcd_out;
  logic        strobe_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_scanner dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_digits (res_digits),
    .res_ovr    (res_ovr),
    .digit_en   (digit_en),
    .bcd_out    (bcd_out),
    .strobe_n   (strobe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(digit_en == 5'd0, "R1", "enables in reset", digit_en, 0);
    chk(bcd_out == 4'd0, "R1", "bcd in reset", bcd_out, 0);
    chk(strobe_n == 1'b1, "R1", "strobe in reset", strobe_n, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk(digit_en == 5'd0, "R1", "enables idle after reset", digit_en, 0);
    chk(bcd_out == 4'd0, "R1", "bcd idle after reset", bcd_out, 0);
    chk(strobe_n == 1'b1, "R1", "strobe idle after reset", strobe_n, 1);
  endtask

  // Offers one result and follows ncyc cycles, comparing every cycle.
  task automatic play(input logic [19:0] d, input bit ovr, input int ncyc);
    int stb_first = 0;
    int stb_later = 0;
    @(negedge clk);
    res_digits = d;
    res_ovr    = ovr;
    res_valid  = 1'b1;
    @(posedge clk); #1;
    res_valid  = 1'b0;
    for (int t = 0; t < ncyc; t++) begin
      int pos = t % PASS_LEN;
      int pass = t / PASS_LEN;
      int slot, c;
      logic [4:0] e_en;
      logic [3:0] e_bcd;
      bit e_low;
      if (pos < SLOT + 1) begin
        slot = 0; c = pos;
      end else begin
        slot = 1 + (pos - SLOT - 1) / SLOT;
        c = (pos - SLOT - 1) % SLOT;
      end
      e_en  = 5'b10000 >> slot;
      e_bcd = ovr ? 4'd0 : d[4*(4-slot) +: 4];
      e_low = (pass == 0) && (c == ((slot == 0) ? SLOT/2 : SLOT/2 - 1));
      if (ovr && t > LAST_STB_T) begin
        e_en = 5'd0; e_bcd = 4'd0; e_low = 1'b0;
      end
      chk(strobe_n == 1'b1, "R6", "strobe in high phase", strobe_n, 1);
      @(negedge clk); #1;
      chk(digit_en == e_en, (ovr && t > LAST_STB_T) ? "R10" : "R3", "digit enables",
          digit_en, e_en);
      chk(bcd_out == e_bcd, ovr ? "R9" : "R4", "bcd value", bcd_out, e_bcd);
      chk(strobe_n == !e_low, (pass == 0) ? "R5" : "R7", "strobe low phase",
          strobe_n, !e_low);
      if (!strobe_n) begin
        if (pass == 0) stb_first++;
        else stb_later++;
      end
      @(posedge clk); #1;
    end
    chk(stb_first == 5, ovr ? "R9" : "R5", "strobes in first pass", stb_first, 5);
    if (ncyc > PASS_LEN)
      chk(stb_later == 0, "R7", "strobes in later passes", stb_later, 0);
  endtask

  task automatic test_normal();   // R2 R3 R4 R5 R6 R7
    play({4'd9, 4'd8, 4'd4, 4'd2, 4'd7}, 1'b0, 2 * PASS_LEN + 10);
  endtask

  task automatic test_restart();  // R8
    @(negedge clk);
    res_digits = {4'd1, 4'd3, 4'd5, 4'd7, 4'd9};
    res_ovr = 1'b0;
    res_valid = 1'b1;
    @(posedge clk); #1;
    res_valid = 1'b0;
    repeat (350) @(posedge clk);
    #1;
    play({4'd6, 4'd0, 4'd2, 4'd8, 4'd3}, 1'b0, PASS_LEN + 20);
    chk(1'b1, "R8", "restart pass compared", 1, 1);
  endtask

  task automatic test_overrange();  // R9 R10
    play({4'd9, 4'd9, 4'd9, 4'd9, 4'd9}, 1'b1, LAST_STB_T + 1500);
    play({4'd0, 4'd5, 4'd0, 4'd5, 4'd1}, 1'b0, PASS_LEN);
  endtask

  initial begin
    check_reset();
    test_normal();
    test_restart();
    test_overrange();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule